// File: doc/BRIEF.md
# Buck Regulator Short-Circuit Guard

This block supervises one buck regulator through a single digitized comparator bit that reads high whenever the regulator output sits below its low-voltage threshold of 0.35 V. When the enable request rises, the block lets the regulator run and waits one detection interval. At the end of that interval it takes one sample of the comparator. If the output is still low at that instant, the block declares a short circuit.

Once the start-up check has passed, the block watches the comparator without pause. If the output stays low for a full interval without a break, the block declares an overload. Either finding switches the regulator off and holds it off. It also sets a sticky interrupt flag. The flag has no mask, and software clears it by pulsing a write-one-to-clear strobe. The regulator runs again only after the enable request has been dropped and raised again, and that restarts the start-up check.

The detection interval is the parameter `INTERVAL_CYC`, given in clock cycles. Its default is 1 ms at 50 MHz. A saturating counter measures the interval.

Top module: `buck_sc_guard`

## Requirements
- R1: While reset is high, and on the first cycle after it, `reg_run_o` and `sc_flag_o` are both 0.
- R2: When `reg_en_i` is sampled high while the regulator is off and no fault is latched, `reg_run_o` is 1 from the next edge. It stays 1 through the whole start-up window of `INTERVAL_CYC` edges, whatever `vout_low_i` does.
- R3: Counting from the edge that started the regulator, the block samples `vout_low_i` at the `INTERVAL_CYC`-th edge. A value of 1 there drives `reg_run_o` to 0 and sets `sc_flag_o` at that same edge. A value of 0 there moves the block into continuous monitoring with `reg_run_o` held at 1. Low readings earlier in the window have no effect.
- R4: During monitoring, `vout_low_i` at 1 on `INTERVAL_CYC` consecutive edges drives `reg_run_o` to 0 and sets `sc_flag_o` at the last of those edges. Any shorter low run leaves both outputs unchanged.
- R5: A single edge with `vout_low_i` at 0 during monitoring restarts the debounce count from zero.
- R6: After a detection, `reg_run_o` stays 0 for as long as `reg_en_i` stays 1, whatever `vout_low_i` and `flag_clr_i` do. After `reg_en_i` falls and then rises again, a fresh start-up check begins as in R2 and R3.
- R7: `sc_flag_o` holds its value until `flag_clr_i` is sampled at 1, which clears it at that edge. A clear while the flag is 0 has no effect.
- R8: If a detection and `flag_clr_i` fall on the same edge, the flag ends at 1.
- R9: `reg_en_i` sampled at 0 drives `reg_run_o` to 0 at that edge. This holds even on the edge where a detection would have fired, in which case `sc_flag_o` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_en_i | input | 1 | Regulator enable request |
| vout_low_i | input | 1 | Comparator bit, 1 when the output is below the low threshold |
| flag_clr_i | input | 1 | Write-one pulse that clears the short-circuit flag |
| reg_run_o | output | 1 | Regulator run permission |
| sc_flag_o | output | 1 | Sticky short-circuit interrupt flag |

## Verification
Two events can land on the same edge: a detection that sets the flag, and a software clear of that flag. The bench first leaves the flag set from an earlier fault. It then pulses the clear on each edge of a fresh start-up window in turn. A clear that comes before the deciding edge must empty the flag. A clear on the deciding edge must lose to the new detection, so the flag reads 1.

Enable removal and timer expiry can also coincide. In that case the bench expects the regulator to be off and the flag to stay at 0.

// File: rtl/buck_sc_guard_pkg.sv
package buck_sc_guard_pkg;

    // Supervisor states
    typedef enum logic [1:0] {
        GS_IDLE   = 2'd0,  // regulator off, waiting for enable
        GS_SOFT   = 2'd1,  // start-up window, single check at its end
        GS_WATCH  = 2'd2,  // continuous debounced monitoring
        GS_LOCKED = 2'd3   // fault latched, regulator held off
    } guard_state_e;

    // Control bundle from the sequencer to the interval counter
    typedef struct packed {
        logic count;  // advance the counter this cycle
        logic wipe;   // return the counter to zero
    } tmr_ctl_t;

    // Run permission for a given state
    function automatic logic state_runs(guard_state_e s);
        return (s == GS_SOFT) || (s == GS_WATCH);
    endfunction

    // Counter width able to hold values up to n
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/buck_sc_interval.sv
module buck_sc_interval
    import buck_sc_guard_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 50000,
    parameter int unsigned CNT_W        = cnt_width(INTERVAL_CYC)
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Saturating counter: parks at LAST until wiped
    always_ff @(posedge clk) begin
        if (rst || ctl_i.wipe) begin
            cnt_q <= '0;
        end else if (ctl_i.count && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry is only meaningful while counting
    assign expired_o = ctl_i.count && (cnt_q == LAST);
    assign cnt_o     = cnt_q;

endmodule

// File: rtl/buck_sc_sequencer.sv
module buck_sc_sequencer
    import buck_sc_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         low_i,
    input  logic         expired_i,
    output guard_state_e state_o,
    output tmr_ctl_t     tmr_o,
    output logic         detect_o
);
    guard_state_e state_q, state_d;
    logic         det;

    always_comb begin
        state_d = state_q;
        det     = 1'b0;
        unique case (state_q)
            GS_IDLE: begin
                if (en_i) state_d = GS_SOFT;
            end
            GS_SOFT: begin
                if (!en_i) begin
                    state_d = GS_IDLE;
                end else if (expired_i) begin
                    // single sample at the end of the start-up window
                    if (low_i) begin
                        state_d = GS_LOCKED;
                        det     = 1'b1;
                    end else begin
                        state_d = GS_WATCH;
                    end
                end
            end
            GS_WATCH: begin
                if (!en_i) begin
                    state_d = GS_IDLE;
                end else if (expired_i) begin
                    // counter only runs while low, so expiry means a full low run
                    state_d = GS_LOCKED;
                    det     = 1'b1;
                end
            end
            GS_LOCKED: begin
                if (!en_i) state_d = GS_IDLE;
            end
            default: state_d = GS_IDLE;
        endcase
    end

    // Counter runs through the whole start-up window, and during
    // monitoring only while the output reads low.
    always_comb begin
        tmr_o.count = (state_q == GS_SOFT) || ((state_q == GS_WATCH) && low_i);
        tmr_o.wipe  = !tmr_o.count || (state_d != state_q);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GS_IDLE;
        else     state_q <= state_d;
    end

    assign state_o  = state_q;
    assign detect_o = det;

endmodule

// File: rtl/buck_sc_flag.sv
module buck_sc_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Set takes priority over a simultaneous software clear
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

endmodule

// File: rtl/buck_sc_guard.sv
module buck_sc_guard
    import buck_sc_guard_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic reg_en_i,
    input  logic vout_low_i,
    input  logic flag_clr_i,
    output logic reg_run_o,
    output logic sc_flag_o
);
    localparam int unsigned CNT_W = cnt_width(INTERVAL_CYC);

    guard_state_e     state;
    tmr_ctl_t         tmr_ctl;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_cnt;
    logic             detect;

    buck_sc_interval #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .CNT_W        (CNT_W)
    ) u_interval (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (tmr_ctl),
        .cnt_o     (tmr_cnt),
        .expired_o (tmr_expired)
    );

    buck_sc_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .en_i      (reg_en_i),
        .low_i     (vout_low_i),
        .expired_i (tmr_expired),
        .state_o   (state),
        .tmr_o     (tmr_ctl),
        .detect_o  (detect)
    );

    buck_sc_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (detect),
        .clr_i  (flag_clr_i),
        .flag_o (sc_flag_o)
    );

    assign reg_run_o = state_runs(state);

endmodule

// File: rtl/buck_sc_guard_chk.sv
module buck_sc_guard_chk
    import buck_sc_guard_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 50000,
    parameter int unsigned CNT_W        = cnt_width(INTERVAL_CYC)
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic             clr_i,
    input logic             run_i,
    input logic             flag_i,
    input guard_state_e     state_i,
    input logic             detect_i,
    input logic [CNT_W-1:0] cnt_i
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

    // R1: first cycle out of reset is idle with the flag clear
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_i == GS_IDLE && !flag_i && !run_i));

    // R2: enable from idle grants run at the next edge
    a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
        (state_i == GS_IDLE && en_i) |=> run_i);

    // R3: a new flag always comes with the regulator switching off
    a_r3_flag_with_off: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_i) |-> $fell(run_i));

    // R4: the debounce counter never passes its limit
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_i <= LAST);

    // R6: latched fault holds while enable stays high
    a_r6_latched: assert property (@(posedge clk) disable iff (rst)
        (state_i == GS_LOCKED && en_i) |=> (state_i == GS_LOCKED && !run_i));

    // R7: flag is sticky without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_i && !clr_i) |=> flag_i);

    // R7: a clear with no detection empties the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !detect_i) |=> !flag_i);

    // R8: detection wins over a simultaneous clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        detect_i |=> flag_i);

    // R9: enable low removes run permission
    a_r9_disable: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !run_i);

endmodule

bind buck_sc_guard buck_sc_guard_chk #(
    .INTERVAL_CYC (INTERVAL_CYC),
    .CNT_W        (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en_i     (reg_en_i),
    .clr_i    (flag_clr_i),
    .run_i    (reg_run_o),
    .flag_i   (sc_flag_o),
    .state_i  (state),
    .detect_i (detect),
    .cnt_i    (tmr_cnt)
);

// File: tb/buck_sc_guard_tb.sv
module buck_sc_guard_tb;
    localparam int unsigned N = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic low = 1'b0;
    logic clr = 1'b0;
    logic run;
    logic flag;

    int n_chk  = 0;
    int n_err  = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    buck_sc_guard #(.INTERVAL_CYC(N)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_en_i   (en),
        .vout_low_i (low),
        .flag_clr_i (clr),
        .reg_run_o  (run),
        .sc_flag_o  (flag)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Advance one edge, land 5 ns after it
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    // Drop enable, clear flag, back to idle
    task automatic to_idle();
        en = 1'b0; low = 1'b0; clr = 1'b0;
        step();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    // From idle, pass start-up and reach monitoring
    task automatic start_run();
        en = 1'b1; low = 1'b0;
        step();
        repeat (N) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs
        en = 1'b1; low = 1'b1;
        repeat (3) step();
        check(run,  1'b0, "R1 run in reset");
        check(flag, 1'b0, "R1 flag in reset");
        en = 1'b0; low = 1'b0; rst = 1'b0;
        step();
        check(run,  1'b0, "R1 run after reset");
        check(flag, 1'b0, "R1 flag after reset");

        // R2/R3: sweep how long the output stays low after enable
        for (int d = 0; d <= N + 1; d++) begin
            en = 1'b1; low = (d > 0);
            step();
            check(run, 1'b1, "R2 run after enable");
            for (int j = 1; j <= N; j++) begin
                low = (j <= d);
                step();
                if (j < N) check(run, 1'b1, "R2 run in window");
            end
            check(run,  (d < N),  "R3 run after start check");
            check(flag, (d >= N), "R3 flag after start check");
            to_idle();
            check(flag, 1'b0, "R7 flag cleared");
        end

        // R4: sweep overload pulse lengths during monitoring
        for (int l = 1; l <= N + 1; l++) begin
            start_run();
            for (int j = 1; j <= l; j++) begin
                low = 1'b1;
                step();
                check(run,  (j < N),  "R4 run during low run");
                check(flag, (j >= N), "R4 flag during low run");
            end
            low = 1'b0;
            repeat (2) step();
            check(run, (l < N), "R4 run after pulse");
            to_idle();
        end

        // R5: one high sample restarts the debounce
        start_run();
        low = 1'b1;
        repeat (N - 1) step();
        low = 1'b0;
        step();
        low = 1'b1;
        repeat (N - 1) step();
        check(run,  1'b1, "R5 run after restarted count");
        check(flag, 1'b0, "R5 flag after restarted count");
        step();
        check(run,  1'b0, "R5 run after full low run");
        check(flag, 1'b1, "R5 flag after full low run");

        // R6: latched off while enable high
        low = 1'b0;
        repeat (N + 3) step();
        check(run,  1'b0, "R6 run stays off");
        check(flag, 1'b1, "R7 flag sticky");
        clr = 1'b1;
        step();
        clr = 1'b0;
        check(flag, 1'b0, "R7 clear at next edge");
        check(run,  1'b0, "R6 clear does not restart");
        en = 1'b0;
        step();
        check(run, 1'b0, "R6 run with enable low");
        en = 1'b1; low = 1'b1;
        step();
        check(run, 1'b1, "R6 run after re-enable");
        repeat (N - 1) step();
        check(run, 1'b1, "R6 fresh window");
        step();
        check(run,  1'b0, "R6 fresh start check fault");
        check(flag, 1'b1, "R6 fresh start check flag");
        to_idle();

        // R7: clear on an empty flag
        clr = 1'b1;
        step();
        clr = 1'b0;
        check(flag, 1'b0, "R7 clear while empty");
        check(run,  1'b0, "R7 idle stays off");

        // R8: clear pulse at each edge of a faulting start-up window
        for (int k = 1; k <= N; k++) begin
            en = 1'b1; low = 1'b1;
            step();
            repeat (N) step();
            en = 1'b0;
            step();
            check(flag, 1'b1, "R8 precondition flag");
            en = 1'b1;
            step();
            for (int j = 1; j <= N; j++) begin
                clr = (j == k);
                step();
                clr = 1'b0;
                if (j == k && j < N) check(flag, 1'b0, "R8 early clear");
            end
            check(flag, 1'b1, "R8 set wins at deciding edge");
            check(run,  1'b0, "R8 run off");
            to_idle();
        end

        // R9: enable drop at the deciding start-up edge
        en = 1'b1; low = 1'b1;
        step();
        repeat (N - 1) step();
        en = 1'b0;
        step();
        check(run,  1'b0, "R9 run off at start edge");
        check(flag, 1'b0, "R9 no flag at start edge");

        // R9: enable drop at the deciding overload edge
        start_run();
        low = 1'b1;
        repeat (N - 1) step();
        en = 1'b0;
        step();
        check(run,  1'b0, "R9 run off at overload edge");
        check(flag, 1'b0, "R9 no flag at overload edge");
        repeat (N + 2) step();
        check(run,  1'b0, "R9 stays off");
        check(flag, 1'b0, "R9 flag stays clear");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule